// File: doc/BRIEF.md
# Shift, Rotate and Multiply-High Execution Unit

This unit executes the register-format shift, rotate and upper-half multiply instructions of a 32-bit core. The issuing stage presents the full instruction word together with the two source operand values and pulses `start`. The unit decodes the instruction, computes the result and returns it with the destination register index and a write-enable for the register file.

Shifts and rotates finish on the clock edge that samples `start`. The multiply-high variants use a radix-2 shift-add engine. It takes one operand bit per cycle and applies a sign correction at the end. While a multiply is in flight `busy` is high and every new `start` is dropped. Instruction words outside this group are dropped too, so the issuing stage can route them elsewhere.

Top module: `shmul_unit`

## Requirements
- R1: A `start` is accepted only when bits [5:0] of the instruction equal 0x3A and bits [16:11] hold one of the extended codes listed in R2, R3 and R7. Any other word produces no `done`.
- R2: Immediate-count forms take the count from instruction bits [10:6]: left shift 0x12, logical right 0x1A, arithmetic right 0x3A, rotate left 0x02.
- R3: Register-count forms take the count from the low five bits of `opb` and ignore its upper bits: left shift 0x13, logical right 0x1B, arithmetic right 0x3B, rotate left 0x03, rotate right 0x0B.
- R4: Logical right shifts fill with zeros. Arithmetic right shifts fill with copies of bit 31 of `opa`. Left shifts fill with zeros.
- R5: Rotates feed the bits shifted out back in at the other end. A count of zero returns `opa` unchanged.
- R6: For an accepted shift or rotate, `done` is high with the result right after the edge that samples `start`.
- R7: Multiply-high returns bits [63:32] of the 64-bit product of `opa` and `opb`. Code 0x07 treats both operands as unsigned. Code 0x17 treats `opa` as signed and `opb` as unsigned. Code 0x1F treats both as signed.
- R8: For an accepted multiply, `busy` rises after the start edge. `done` and the result appear after the 34th rising edge, counting the start edge as the first. `busy` falls on that same edge.
- R9: A `start` while `busy` is high is ignored. It gives no `done`, and it does not change the result or destination of the multiply in flight.
- R10: With `done`, `dest` carries instruction bits [21:17] of the completing instruction. `wr_en` is high only when `done` is high and `dest` is nonzero.
- R11: After synchronous reset, `done`, `wr_en` and `busy` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe for the instruction on `insn` |
| insn | input | 32 | Instruction word |
| opa | input | 32 | First source operand (rA value) |
| opb | input | 32 | Second source operand (rB value) |
| busy | output | 1 | Multiply in progress; new starts dropped |
| done | output | 1 | One-cycle result-valid pulse |
| wr_en | output | 1 | Register write request |
| dest | output | 5 | Destination register index |
| result | output | 32 | Result value |

## Verification
The assertions assume that `insn`, `opa` and `opb` are valid whenever `start` is high. They also assume that `start` is sampled only on rising edges and may be held for exactly one cycle. The assertions make no assumption about `start` during `busy`, because the unit must drop it there. The stimulus changes inputs only on the falling edge and drops `start` right after each accepting edge. It deliberately raises `start` in the middle of a multiply and with undecodable words, so the ignore paths are exercised.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned OPX_LSB = 11;
  localparam int unsigned OPX_W   = 6;
  localparam int unsigned IMM_LSB = 6;
  localparam int unsigned DST_LSB = 17;
  localparam int unsigned DST_W   = 5;

  localparam logic [OPC_W-1:0] OPC_REGFMT = 6'h3A;

  localparam logic [OPX_W-1:0] X_ROLI  = 6'h02;
  localparam logic [OPX_W-1:0] X_ROL   = 6'h03;
  localparam logic [OPX_W-1:0] X_MULUU = 6'h07;
  localparam logic [OPX_W-1:0] X_ROR   = 6'h0B;
  localparam logic [OPX_W-1:0] X_SLLI  = 6'h12;
  localparam logic [OPX_W-1:0] X_SLL   = 6'h13;
  localparam logic [OPX_W-1:0] X_MULSU = 6'h17;
  localparam logic [OPX_W-1:0] X_SRLI  = 6'h1A;
  localparam logic [OPX_W-1:0] X_SRL   = 6'h1B;
  localparam logic [OPX_W-1:0] X_MULSS = 6'h1F;
  localparam logic [OPX_W-1:0] X_SRAI  = 6'h3A;
  localparam logic [OPX_W-1:0] X_SRA   = 6'h3B;

  typedef enum logic [3:0] {
    K_NONE, K_SLL, K_SRL, K_SRA, K_ROL, K_ROR, K_MUU, K_MSU, K_MSS
  } kind_e;

  typedef struct packed {
    logic  valid;
    logic  is_mul;
    logic  use_imm;
    kind_e kind;
  } dec_t;

endpackage

// File: rtl/shmul_decode.sv
module shmul_decode
  import shmul_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic [OPX_W-1:0] opx;
  assign opx = insn[OPX_LSB +: OPX_W];

  always_comb begin
    dec = '{valid: 1'b1, is_mul: 1'b0, use_imm: 1'b0, kind: K_NONE};
    unique case (opx)
      X_SLLI:  begin dec.kind = K_SLL; dec.use_imm = 1'b1; end
      X_SRLI:  begin dec.kind = K_SRL; dec.use_imm = 1'b1; end
      X_SRAI:  begin dec.kind = K_SRA; dec.use_imm = 1'b1; end
      X_ROLI:  begin dec.kind = K_ROL; dec.use_imm = 1'b1; end
      X_SLL:   dec.kind = K_SLL;
      X_SRL:   dec.kind = K_SRL;
      X_SRA:   dec.kind = K_SRA;
      X_ROL:   dec.kind = K_ROL;
      X_ROR:   dec.kind = K_ROR;
      X_MULUU: begin dec.kind = K_MUU; dec.is_mul = 1'b1; end
      X_MULSU: begin dec.kind = K_MSU; dec.is_mul = 1'b1; end
      X_MULSS: begin dec.kind = K_MSS; dec.is_mul = 1'b1; end
      default: dec.valid = 1'b0;
    endcase
    if (insn[OPC_W-1:0] != OPC_REGFMT) dec.valid = 1'b0;
  end
endmodule

// File: rtl/shmul_shifter.sv
module shmul_shifter
  import shmul_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  kind_e            kind,
  input  logic [XLEN-1:0]  a,
  input  logic [SHW-1:0]   amt,
  output logic [XLEN-1:0]  y
);
  logic [2*XLEN-1:0] dbl, dbl_l, dbl_r;

  assign dbl   = {a, a};
  assign dbl_l = dbl << amt;
  assign dbl_r = dbl >> amt;

  always_comb begin
    unique case (kind)
      K_SLL:   y = a << amt;
      K_SRL:   y = a >> amt;
      K_SRA:   y = XLEN'($signed(a) >>> amt);
      K_ROL:   y = dbl_l[2*XLEN-1:XLEN];
      K_ROR:   y = dbl_r[XLEN-1:0];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/shmul_mulhi.sv
module shmul_mulhi #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            a_sgn,
  input  logic            b_sgn,
  output logic            busy,
  output logic            fin,
  output logic [XLEN-1:0] hi_out
);
  typedef enum logic [1:0] {M_IDLE, M_RUN, M_FIX} mst_e;

  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  mst_e            st;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] hi, lo, mcand, bkeep;
  logic            a_neg, b_neg;
  logic [XLEN:0]   sum;

  assign sum = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= M_IDLE; cnt <= '0; hi <= '0; lo <= '0;
      mcand <= '0; bkeep <= '0; a_neg <= 1'b0; b_neg <= 1'b0;
    end else begin
      unique case (st)
        M_IDLE: if (load) begin
          mcand <= a;
          bkeep <= b;
          lo    <= b;
          hi    <= '0;
          cnt   <= '0;
          a_neg <= a_sgn & a[XLEN-1];
          b_neg <= b_sgn & b[XLEN-1];
          st    <= M_RUN;
        end
        M_RUN: begin
          hi  <= sum[XLEN:1];
          lo  <= {sum[0], lo[XLEN-1:1]};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= M_FIX;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assign busy   = (st != M_IDLE);
  assign fin    = (st == M_FIX);
  assign hi_out = hi - (a_neg ? bkeep : '0) - (b_neg ? mcand : '0);

  AST_MUL_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (busy && !fin && cnt == '0)); // R8
  AST_MUL_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == M_RUN && cnt != LAST) |=> (st == M_RUN)); // R8
  AST_MUL_FIX_ONCE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy); // R8
endmodule

// File: rtl/shmul_unit.sv
module shmul_unit
  import shmul_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic            wr_en,
  output logic [DST_W-1:0] dest,
  output logic [XLEN-1:0] result
);
  localparam int unsigned SHW = $clog2(XLEN);

  dec_t             dec;
  logic [SHW-1:0]   amt;
  logic [XLEN-1:0]  sh_y, mul_hi;
  logic             mul_busy, mul_fin, accept, mul_load;
  logic [DST_W-1:0] insn_dst, pend_dst;

  shmul_decode u_dec (.insn(insn), .dec(dec));

  assign amt      = dec.use_imm ? insn[IMM_LSB +: SHW] : opb[SHW-1:0];
  assign insn_dst = insn[DST_LSB +: DST_W];
  assign accept   = start && !mul_busy && dec.valid;
  assign mul_load = accept && dec.is_mul;

  shmul_shifter #(.XLEN(XLEN)) u_sh (
    .kind(dec.kind), .a(opa), .amt(amt), .y(sh_y)
  );

  shmul_mulhi #(.XLEN(XLEN)) u_mul (
    .clk(clk), .rst(rst), .load(mul_load), .a(opa), .b(opb),
    .a_sgn(dec.kind == K_MSS || dec.kind == K_MSU),
    .b_sgn(dec.kind == K_MSS),
    .busy(mul_busy), .fin(mul_fin), .hi_out(mul_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; wr_en <= 1'b0; dest <= '0; result <= '0; pend_dst <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (mul_fin) begin
        done   <= 1'b1;
        result <= mul_hi;
        dest   <= pend_dst;
        wr_en  <= (pend_dst != '0);
      end else if (accept && !dec.is_mul) begin
        done   <= 1'b1;
        result <= sh_y;
        dest   <= insn_dst;
        wr_en  <= (insn_dst != '0);
      end
      if (mul_load) pend_dst <= insn_dst;
    end
  end

  assign busy = mul_busy;

  AST_BAD_WORD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (start && !dec.valid && !mul_busy) |=> !done); // R1
  AST_SRA_FILL: assert property (@(posedge clk) disable iff (rst)
    (accept && dec.kind == K_SRA) |=> (result[XLEN-1] == $past(opa[XLEN-1]))); // R4
  AST_SHIFT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec.is_mul) |=> done); // R6
  AST_FIN_DONE: assert property (@(posedge clk) disable iff (rst)
    mul_fin |=> (done && !busy)); // R8
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mul_busy && !mul_fin) |=> !done); // R9
  AST_WR_DEST: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (done && dest != '0)); // R10
endmodule

// File: tb/shmul_unit_test.sv
module shmul_unit_test;
  localparam time CLK = 10ns;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] insn = '0, opa = '0, opb = '0;
  logic        busy, done, wr_en;
  logic [4:0]  dest;
  logic [31:0] result;

  int total = 0, bad = 0;

  shmul_unit uut (
    .clk(clk), .rst(rst), .start(start), .insn(insn), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .wr_en(wr_en), .dest(dest), .result(result)
  );

  always #(CLK/2) clk = ~clk;

  initial begin
    #(CLK*150000);
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opx, input logic [4:0] imm, input logic [4:0] dst);
    return {5'd1, 5'd2, dst, opx, imm, 6'h3A};
  endfunction

  function automatic logic [31:0] e_rol(input logic [31:0] a, input int n);
    return (n == 0) ? a : ((a << n) | (a >> (32 - n)));
  endfunction
  function automatic logic [31:0] e_ror(input logic [31:0] a, input int n);
    return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
  endfunction
  function automatic logic [31:0] e_mul(input int k, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] x, y, p;
    x = (k >= 1) ? {{32{a[31]}}, a} : {32'b0, a};
    y = (k == 2) ? {{32{b[31]}}, b} : {32'b0, b};
    p = x * y;
    return p[63:32];
  endfunction

  // issue one instruction, return latency in edges (start edge = 1)
  task automatic run_op(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        output int lat);
    @(negedge clk);
    insn = w; opa = a; opb = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic no_done(input string req, input logic [31:0] w);
    int seen = 0;
    @(negedge clk);
    insn = w; opa = 32'h1234_5678; opb = 32'h3; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done) seen++;
      @(posedge clk); #1;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 done", done, 0);
    check("R11 wr_en", wr_en, 0);
    check("R11 busy", busy, 0);
    check("R11 result", result, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_imm_shifts();
    int lat;
    run_op(mk(6'h12, 5'd4, 5'd3), 32'h8765_4321, 32'hFFFF_FFFF, lat);
    check("R2 slli", result, 32'h7654_3210);
    check("R6 slli latency", lat, 1);
    check("R10 dest", dest, 3);
    check("R10 wr_en", wr_en, 1);
    run_op(mk(6'h1A, 5'd8, 5'd4), 32'h8765_4321, 32'h0, lat);
    check("R4 srli zero fill", result, 32'h0087_6543);
    run_op(mk(6'h3A, 5'd8, 5'd5), 32'h8765_4321, 32'h0, lat);
    check("R4 srai sign fill", result, 32'hFF87_6543);
    run_op(mk(6'h02, 5'd31, 5'd6), 32'h8000_0001, 32'h0, lat);
    check("R5 roli 31", result, e_rol(32'h8000_0001, 31));
  endtask

  task automatic t_reg_shifts();
    int lat;
    run_op(mk(6'h13, 5'd0, 5'd7), 32'h0000_00F1, 32'hFFFF_FFE3, lat);
    check("R3 sll uses opb[4:0]", result, 32'h0000_0788);
    run_op(mk(6'h1B, 5'd9, 5'd7), 32'hF000_0000, 32'h0000_0104, lat);
    check("R3 srl ignores imm field", result, 32'h0F00_0000);
    run_op(mk(6'h3B, 5'd0, 5'd7), 32'h4000_0000, 32'h0000_001F, lat);
    check("R4 sra positive", result, 32'h0000_0000);
    run_op(mk(6'h3B, 5'd0, 5'd7), 32'h8000_0000, 32'h0000_003F, lat);
    check("R4 sra negative", result, 32'hFFFF_FFFF);
    run_op(mk(6'h03, 5'd0, 5'd8), 32'hDEAD_BEEF, 32'h0000_0024, lat);
    check("R5 rol", result, e_rol(32'hDEAD_BEEF, 4));
    run_op(mk(6'h0B, 5'd0, 5'd8), 32'hDEAD_BEEF, 32'h0000_000C, lat);
    check("R5 ror", result, e_ror(32'hDEAD_BEEF, 12));
    check("R6 ror latency", lat, 1);
    run_op(mk(6'h0B, 5'd0, 5'd8), 32'hDEAD_BEEF, 32'hFFFF_FFE0, lat);
    check("R5 ror by zero", result, 32'hDEAD_BEEF);
  endtask

  task automatic t_mul();
    int lat;
    logic [31:0] a, b;
    for (int i = 0; i < 4; i++) begin
      a = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h8000_0000 : (i == 2) ? 32'h1234_5678 : 32'h7FFF_FFFF;
      b = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h8000_0000 : (i == 2) ? 32'hFEDC_BA98 : 32'h8000_0001;
      run_op(mk(6'h07, 5'd0, 5'd9), a, b, lat);
      check("R7 mulxuu", result, e_mul(0, a, b));
      check("R8 mul latency", lat, 34);
      check("R8 busy low at done", busy, 0);
      run_op(mk(6'h17, 5'd0, 5'd10), a, b, lat);
      check("R7 mulxsu", result, e_mul(1, a, b));
      run_op(mk(6'h1F, 5'd0, 5'd11), a, b, lat);
      check("R7 mulxss", result, e_mul(2, a, b));
      check("R10 mul dest", dest, 11);
    end
  endtask

  task automatic t_busy_ignore();
    int lat = 1, dn = 0;
    @(negedge clk);
    insn = mk(6'h1F, 5'd0, 5'd12); opa = 32'hFFFF_FFFE; opb = 32'h0000_0003; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R8 busy after start", busy, 1);
    repeat (4) begin @(posedge clk); #1; lat++; end
    @(negedge clk);
    insn = mk(6'h12, 5'd1, 5'd13); opa = 32'h1; start = 1'b1;
    @(posedge clk); #1; lat++;
    start = 1'b0;
    check("R9 no done from dropped start", done, 0);
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    check("R9 latency unchanged", lat, 34);
    check("R9 result kept", result, e_mul(2, 32'hFFFF_FFFE, 32'h3));
    check("R9 dest kept", dest, 12);
    for (int i = 0; i < 3; i++) begin @(posedge clk); #1; if (done) dn++; end
    check("R9 single done", dn, 0);
  endtask

  task automatic t_zero_dest();
    int lat;
    run_op(mk(6'h12, 5'd1, 5'd0), 32'h5, 32'h0, lat);
    check("R10 done with r0", done, 1);
    check("R10 no write to r0", wr_en, 0);
    run_op(mk(6'h07, 5'd0, 5'd0), 32'h5, 32'h7, lat);
    check("R10 mul no write to r0", wr_en, 0);
  endtask

  task automatic t_bad_words();
    no_done("R1 wrong major opcode", {5'd1, 5'd2, 5'd3, 6'h12, 5'd1, 6'h04});
    no_done("R1 unsupported opx", mk(6'h31, 5'd0, 5'd3));
    no_done("R1 unsupported opx 0x00", mk(6'h00, 5'd0, 5'd3));
  endtask

  initial begin
    t_reset();
    t_imm_shifts();
    t_reg_shifts();
    t_mul();
    t_busy_ignore();
    t_zero_dest();
    t_bad_words();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule